// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Timing Controller

This block sits between a synchronous host and an asynchronous static RAM. The host offers one request per handshake: a read or a write with an address, write data and a lane mask. The controller then drives the memory's select, write-enable, output-enable and lane-select strobes for exactly as many clock cycles as the memory's minimum timings require. Every minimum is given in nanoseconds and turned into a cycle count with `ceil(t_ns / CLK_PERIOD_NS)`, and any nonzero time gets at least one cycle.

A read raises all of its strobes in the first cycle after acceptance. It holds them long enough to cover the slowest of the address, select, lane and output-enable access times, then samples the data bus and returns it with a one-cycle valid pulse. A write keeps output enable high the whole time. It releases its data driver only after a bus-release window that follows the fall of write enable, and it holds the pulse long enough for the pulse width, the address-to-end time and the data-to-end overlap. When the minimum cycle time is longer than the strobe window, idle recovery cycles are added. A request whose lane mask is all zero finishes in a single cycle and drives no strobe.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, ready is high, select, write enable, output enable and both lane selects are high (inactive), the data driver is off and read-data-valid is low.
- R2: An accepted read with a nonzero mask drives select, output enable and the active-low lane selects low from the first cycle after acceptance for RD = max(ceil(55/P), ceil(45/P), ceil(22/P)) cycles, with P the clock period in ns. Write enable stays high during these cycles. Lane select bit i is low exactly when mask bit i is 1. The memory address equals the accepted address and does not change while select is low.
- R3: Read-data-valid is high for one cycle, in the first cycle after the read strobes end. Read data lane i (bits 8i+7..8i) holds the memory data sampled in the last strobe cycle when mask bit i is 1, and holds zero otherwise.
- R4: An accepted write with a nonzero mask drives select, write enable and the masked lane selects low for WE = max(ceil(35/P), ceil(35/P), ceil(18/P) + ceil(25/P)) cycles. Output enable stays high, and write enable and output enable are never low together.
- R5: During a write pulse the data driver is off for the first ceil(18/P) cycles and on for the remaining cycles. It turns off in the same cycle as write enable rises. The data bus carries the accepted write data, and the driver is never on outside a write pulse.
- R6: After acceptance, ready is low for max(RD, ceil(T_RC/P)) cycles for a read and max(WE, ceil(T_WC/P)) cycles for a write. Ready is then high again, and no strobe is active while ready is high.
- R7: A request with an all-zero mask drives no strobe and keeps ready low for one cycle. A read returns read-data-valid with all-zero data one cycle later. A write leaves memory contents unchanged.
- R8: While ready is low the request inputs are ignored: no request is accepted, and the address, lanes and write data in use do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request word address |
| req_wdata_i | input | LANES*LANE_W | Write data |
| req_be_i | input | LANES | Lane mask, bit i enables lane i |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | LANES*LANE_W | Read data, disabled lanes zero |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_cs_no | output | 1 | Memory select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_lane_no | output | LANES | Lane selects, active low |
| mem_dq_o | output | LANES*LANE_W | Data toward memory |
| mem_dq_oe_o | output | 1 | Enable for the data driver |
| mem_dq_i | input | LANES*LANE_W | Data from memory |

## Verification
The hardest situation to reach is a write that follows a read with no idle cycle between them, which is where the bus-release window matters. The bench issues requests back to back at the first ready cycle so that each write pulse starts right after a read's strobes end. In every cycle it checks that the data driver waits out the release cycles. Recovery cycles appear only when the minimum cycle time exceeds the strobe window, so the bench lengthens the write cycle time to force them. It also holds a changed request on the inputs throughout a busy period to show that nothing is taken in.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_RECOV = 3'd3,
    ST_SKIP  = 3'd4
  } seq_st_e;

  // whole cycles covering t_ns; zero stays zero
  function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned per_ns);
    return (t_ns == 0) ? 0 : (t_ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && (cnt_q != '1)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

endmodule

// File: rtl/sramc_rdcap.sv
module sramc_rdcap #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (cap_i) begin
        lane_q <= be_i[l] ? din_i[l*LANE_W +: LANE_W] : '0;
      end
    end
    assign rdata_o[l*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned RD_BSY = 3,
  parameter int unsigned WE_CYC = 3,
  parameter int unsigned WR_BSY = 3,
  parameter int unsigned HZ_CYC = 1,
  parameter int unsigned CNT_W  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic write_i,
  input  logic any_i,
  output logic ready_o,
  output logic sel_o,
  output logic we_o,
  output logic oe_o,
  output logic dq_oe_o,
  output logic cap_o,
  output logic rvalid_o
);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RDB_LAST = CNT_W'(RD_BSY - 1);
  localparam logic [CNT_W-1:0] WRB_LAST = CNT_W'(WR_BSY - 1);
  localparam logic [CNT_W-1:0] HZ_V     = CNT_W'(HZ_CYC);

  seq_st_e          st_q, st_d;
  logic             wr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_d, we_d, oe_d, dqoe_d, cap;
  logic             sel_q, we_q, oe_q, dqoe_q, rv_q;

  sramc_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .en_i       (1'b1),
    .cnt_o      (cnt_q),
    .cnt_next_o (cnt_d)
  );

  always_comb begin
    st_d = st_q;
    cap  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!any_i)       st_d = ST_SKIP;
          else if (write_i) st_d = ST_WRITE;
          else              st_d = ST_READ;
        end
      end
      ST_READ: begin
        if (cnt_q == RD_LAST) begin
          cap  = 1'b1;
          st_d = (RD_BSY > RD_CYC) ? ST_RECOV : ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (cnt_q == WE_LAST) st_d = (WR_BSY > WE_CYC) ? ST_RECOV : ST_IDLE;
      end
      ST_RECOV: begin
        if (cnt_q == (wr_q ? WRB_LAST : RDB_LAST)) st_d = ST_IDLE;
      end
      ST_SKIP: begin
        cap  = !wr_q;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state so they leave flops glitch free
  always_comb begin
    sel_d  = (st_d == ST_READ) || (st_d == ST_WRITE);
    we_d   = (st_d == ST_WRITE);
    oe_d   = (st_d == ST_READ);
    dqoe_d = (st_d == ST_WRITE) && (cnt_d >= HZ_V);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      we_q   <= 1'b0;
      oe_q   <= 1'b0;
      dqoe_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      we_q   <= we_d;
      oe_q   <= oe_d;
      dqoe_q <= dqoe_d;
      rv_q   <= cap;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
    end else if (start_i) begin
      wr_q <= write_i;
    end
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign sel_o    = sel_q;
  assign we_o     = we_q;
  assign oe_o     = oe_q;
  assign dq_oe_o  = dqoe_q;
  assign cap_o    = cap;
  assign rvalid_o = rv_q;

  // R4
  we_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && oe_q));
  // R5
  dq_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqoe_q |-> (we_q && sel_q));
  // R5
  dq_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((HZ_CYC > 0) && $rose(dqoe_q)) |-> $past(we_q));
  // R3
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_q |=> !rv_q);
  // R6
  idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !sel_q);

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned LANES         = 2,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_ACS_NS      = 45,
  parameter int unsigned T_BA_NS       = 45,
  parameter int unsigned T_OE_NS       = 22,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_WP_NS       = 35,
  parameter int unsigned T_AW_NS       = 35,
  parameter int unsigned T_DW_NS       = 25,
  parameter int unsigned T_HZ_NS       = 18,
  localparam int unsigned DATA_W       = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_lane_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned P      = CLK_PERIOD_NS;
  localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_AA_NS, P), ns2cyc(T_ACS_NS, P)),
                                        umax(ns2cyc(T_BA_NS, P), ns2cyc(T_OE_NS, P)));
  localparam int unsigned HZ_CYC = ns2cyc(T_HZ_NS, P);
  localparam int unsigned WE_CYC = umax(umax(ns2cyc(T_WP_NS, P), ns2cyc(T_AW_NS, P)),
                                        HZ_CYC + ns2cyc(T_DW_NS, P));
  localparam int unsigned RD_BSY = umax(RD_CYC, ns2cyc(T_RC_NS, P));
  localparam int unsigned WR_BSY = umax(WE_CYC, ns2cyc(T_WC_NS, P));
  localparam int unsigned CNT_W  = $clog2(umax(RD_BSY, WR_BSY) + 1);

  logic              accept, sel, we, oe, dq_oe, cap;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  sramc_seq #(
    .RD_CYC (RD_CYC),
    .RD_BSY (RD_BSY),
    .WE_CYC (WE_CYC),
    .WR_BSY (WR_BSY),
    .HZ_CYC (HZ_CYC),
    .CNT_W  (CNT_W)
  ) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .write_i  (req_write_i),
    .any_i    (|req_be_i),
    .ready_o  (req_ready_o),
    .sel_o    (sel),
    .we_o     (we),
    .oe_o     (oe),
    .dq_oe_o  (dq_oe),
    .cap_o    (cap),
    .rvalid_o (rsp_valid_o)
  );

  sramc_rdcap #(.LANES(LANES), .LANE_W(LANE_W)) rdcap_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .be_i    (be_q),
    .din_i   (mem_dq_i),
    .rdata_o (rsp_rdata_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_cs_no   = !sel;
  assign mem_we_no   = !we;
  assign mem_oe_no   = !oe;
  assign mem_lane_no = ~(be_q & {LANES{sel}});
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe;

  // R2
  lane_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_no |-> (&mem_lane_no));
  // R8
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

endmodule

// File: tb/sramc_ctrl_tb.sv
module sramc_ctrl_tb_top;

  localparam int P     = 20;
  localparam int AW    = 20;
  localparam int WC_NS = 95;

  function automatic int c(input int t);
    return (t == 0) ? 0 : (t + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HZ   = c(18);
  localparam int S_RD = mx(mx(c(55), c(45)), c(22));
  localparam int S_WR = mx(c(35), HZ + c(25));
  localparam int B_RD = mx(S_RD, c(55));
  localparam int B_WR = mx(S_WR, c(WC_NS));

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_be;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]    mem_lane_n;
  logic [15:0]   mem_dq_o, mem_dq_i;

  int checks = 0;
  int errors = 0;

  logic [15:0] model   [16];
  logic [15:0] exp_mem [16];

  always #10 clk = ~clk;

  sramc_ctrl #(.CLK_PERIOD_NS(P), .ADDR_W(AW), .T_WC_NS(WC_NS)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_be_i    (req_be),
    .req_ready_o (req_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .mem_addr_o  (mem_addr),
    .mem_cs_no   (mem_cs_n),
    .mem_we_no   (mem_we_n),
    .mem_oe_no   (mem_oe_n),
    .mem_lane_no (mem_lane_n),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe),
    .mem_dq_i    (mem_dq_i)
  );

  // memory model: disabled lanes return a filler so masking is visible
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n) ?
    { mem_lane_n[1] ? 8'hA5 : model[mem_addr[3:0]][15:8],
      mem_lane_n[0] ? 8'hA5 : model[mem_addr[3:0]][7:0] } : 16'h5A5A;

  always @(negedge clk) begin
    if (rst_n && !mem_cs_n && !mem_we_n && mem_dq_oe) begin
      for (int l = 0; l < 2; l++)
        if (!mem_lane_n[l]) model[mem_addr[3:0]][l*8 +: 8] = mem_dq_o[l*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input bit wr, input logic [3:0] a, input logic [15:0] d,
                    input logic [1:0] be, input bit hold);
    int s, b, rvc, last;
    logic [15:0] expd;
    logic [6:0]  exp_v, act_v;
    bit strobe;
    chk(req_ready == 1'b1, "R6 ready before request", 32'(req_ready), 32'd1);
    expd = { be[1] ? exp_mem[a][15:8] : 8'h00, be[0] ? exp_mem[a][7:0] : 8'h00 };
    if (wr) begin
      if (be[1]) exp_mem[a][15:8] = d[15:8];
      if (be[0]) exp_mem[a][7:0]  = d[7:0];
    end
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    s    = wr ? S_WR : S_RD;
    b    = (be == 2'b00) ? 1 : (wr ? B_WR : B_RD);
    rvc  = (be == 2'b00) ? 1 : s;
    last = mx(b, rvc);
    @(negedge clk);
    if (hold) begin
      req_addr = AW'(a ^ 4'h1); req_wdata = ~d; req_be = ~be; req_write = !wr;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k <= last; k++) begin
      strobe = (be != 2'b00) && (k < s);
      exp_v = { k >= b, !strobe, !(strobe && wr), !(strobe && !wr),
                strobe ? ~be : 2'b11, strobe && wr && (k >= HZ) };
      act_v = { req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe };
      chk(act_v == exp_v, wr ? "R4 R5 R6 R7 write strobe pattern" : "R2 R6 R7 read strobe pattern",
          32'(act_v), 32'(exp_v));
      if (strobe) chk(mem_addr == AW'(a), "R2 R8 address held", 32'(mem_addr), 32'(a));
      if (strobe && wr && k >= HZ) chk(mem_dq_o == d, "R5 R8 write data", 32'(mem_dq_o), 32'(d));
      chk(rsp_valid == (!wr && k == rvc), "R3 read valid pulse", 32'(rsp_valid), 32'(!wr && k == rvc));
      if (!wr && k == rvc) chk(rsp_rdata == expd, "R3 R7 read data", 32'(rsp_rdata), 32'(expd));
      if (hold && k == b) req_valid = 1'b0;
      if (k < last) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    for (int i = 0; i < 16; i++) begin
      model[i]   = 16'(i * 16'h1111) ^ 16'h0F0F;
      exp_mem[i] = 16'(i * 16'h1111) ^ 16'h0F0F;
    end
    repeat (3) @(negedge clk);
    // R1 in reset
    chk({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rsp_valid} == 8'b11111100,
        "R1 state in reset", 32'({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rsp_valid}), 32'hFC);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    chk({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rsp_valid} == 8'b11111100,
        "R1 state after release", 32'({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rsp_valid}), 32'hFC);

    for (int a = 0; a < 16; a++)
      for (int be = 0; be < 4; be++)
        op(1'b1, 4'(a), 16'(a * 16'h0321 + be * 16'h4B07), 2'(be), 1'b0);
    for (int a = 0; a < 16; a++)
      for (int be = 0; be < 4; be++)
        op(1'b0, 4'(a), 16'h0, 2'(be), 1'b0);
    // read then write back to back: turnaround
    for (int a = 0; a < 16; a++) begin
      op(1'b0, 4'(a), 16'h0, 2'b11, 1'b0);
      op(1'b1, 4'(a), 16'(16'hC3A0 ^ a), 2'(1 + a % 3), 1'b0);
      op(1'b0, 4'(a), 16'h0, 2'b11, 1'b0);
    end
    // R8 request held and changed during busy
    op(1'b0, 4'd5, 16'h0, 2'b11, 1'b1);
    op(1'b1, 4'd6, 16'hBEEF, 2'b10, 1'b1);
    op(1'b0, 4'd6, 16'h0, 2'b11, 1'b0);
    op(1'b1, 4'd7, 16'h1234, 2'b00, 1'b1);
    op(1'b0, 4'd7, 16'h0, 2'b11, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule